// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue channel. Software fills the table through a 32-bit bus port that only accepts writes and exposes two registers. The first is an index register, which picks the entry to update. The second is a data register that takes the red, green and blue values one write at a time. A small phase sequencer tracks which channel the next data write goes to. After the blue channel is written, the sequencer moves the index to the next entry, so software can stream a whole palette after a single index write.

In every write, the colour value sits in the top byte of the 32-bit data word. A separate lookup port lets the display pipeline read an entry's 24-bit colour by pixel index. The lookup port returns its result one clock after the index is presented and does not depend on the write port.

Top module: `clut_port`

## Requirements
- R1: A write to byte offset 0x0 loads the entry index from `bus_wdata[31:24]` and sets the channel phase back to red, even partway through a colour.
- R2: Each write to byte offset 0x4 stores `bus_wdata[31:24]` into one channel of the current entry. The channel is red, then green, then blue in turn, and the phase moves on after each write.
- R3: The data write that fills blue increments the index modulo 256 (255 wraps to 0) and returns the phase to red.
- R4: `bus_rdata` reads as zero at all times.
- R5: A write whose `bus_wstrb` is not 4'b1111 is dropped. It changes no entry, no index and no phase.
- R6: A write to any offset other than 0x0 or 0x4 (for example 0x2, 0x8, 0xC) is ignored.
- R7: Synchronous active-high reset clears every entry to black, except entry 255, which becomes white (0xFFFFFF). It also sets the index to 0 and the phase to red.
- R8: `pix_rgb` is {red, green, blue} (red in bits [23:16]) of entry `pix_idx`, registered one clock after `pix_idx` is sampled. A write to the same entry in that same clock edge is not visible; the old value is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write request for this cycle |
| bus_addr | input | 4 | Byte offset within the 16-byte register window |
| bus_wdata | input | 32 | Write data; only bits [31:24] are used |
| bus_wstrb | input | 4 | Byte strobes; the write takes effect only when all are set |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Entry to fetch on the lookup port |
| pix_rgb | output | 24 | Registered colour of the fetched entry |

## Verification
Each check below targets a specific fault:
- **Index wrap past 255.** A sequencer that saturates would overwrite entry 255 a second time instead of reaching entry 0.
- **Index reload partway through a colour.** If the reload does not reset the phase, green lands in the red slot of the new entry.
- **Dropped partial-strobe writes and stray offsets.** Each is followed by a complete red/green/blue triple. A design that still advanced its phase, or decoded only one address bit, shows a rotated or corrupted colour.
- **Write and lookup to the same entry in one edge.** This confirms the lookup port returns the previous colour rather than forwarding the new one.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int CH_W     = 8;
    localparam int RGB_W    = 3 * CH_W;
    localparam int BUS_W    = 32;
    localparam int OFFS_W   = 4;
    localparam int STRB_W   = BUS_W / 8;

    localparam logic [OFFS_W-1:0] OFF_INDEX = 4'h0;
    localparam logic [OFFS_W-1:0] OFF_COLOR = 4'h4;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
    } rgb_t;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam rgb_t RGB_BLACK = '{red: '0, grn: '0, blu: '0};
    localparam rgb_t RGB_WHITE = '{red: '1, grn: '1, blu: '1};

    function automatic phase_e phase_next(input phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_decode.sv
module clut_decode
    import clut_pkg::*;
(
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] addr,
    input  logic [STRB_W-1:0] wstrb,
    output logic              idx_load,
    output logic              col_push
);
    logic full_word;

    always_comb begin
        full_word = wr_en && (wstrb == {STRB_W{1'b1}});
        idx_load  = full_word && (addr == OFF_INDEX);
        col_push  = full_word && (addr == OFF_COLOR);
    end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_load,
    input  logic             col_push,
    input  logic [CH_W-1:0]  byte_in,
    output logic [IDX_W-1:0] cur_idx,
    output phase_e           cur_phase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
        end else if (idx_load) begin
            cur_idx   <= byte_in[CH_W-1 -: IDX_W];
            cur_phase <= PH_RED;
        end else if (col_push) begin
            if (cur_phase == PH_BLU || cur_phase == PH_GRN + 2'd2)
                cur_idx <= cur_idx + 1'b1;
            cur_phase <= phase_next(cur_phase);
        end
    end

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        idx_load |=> (cur_idx == $past(byte_in[CH_W-1 -: IDX_W])) && (cur_phase == PH_RED)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (col_push && !idx_load && cur_phase == PH_RED) |=> (cur_phase == PH_GRN) && $stable(cur_idx)); // R2
    AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (col_push && !idx_load && cur_phase == PH_BLU) |=>
            (cur_phase == PH_RED) && (cur_idx == IDX_W'($past(cur_idx) + 1'b1))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!idx_load && !col_push) |=> $stable(cur_idx) && $stable(cur_phase)); // R6
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  phase_e           w_phase,
    input  logic [CH_W-1:0]  w_byte,
    input  logic [IDX_W-1:0] r_idx,
    output rgb_t             r_rgb
);
    rgb_t lut_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam rgb_t INIT = (e == ENTRIES - 1) ? RGB_WHITE : RGB_BLACK;
        always_ff @(posedge clk) begin
            if (rst) begin
                lut_q[e] <= INIT;
            end else if (we && w_idx == IDX_W'(e)) begin
                case (w_phase)
                    PH_RED:  lut_q[e].red <= w_byte;
                    PH_GRN:  lut_q[e].grn <= w_byte;
                    PH_BLU:  lut_q[e].blu <= w_byte;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_rgb <= RGB_BLACK;
        else     r_rgb <= lut_q[r_idx];
    end
endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [STRB_W-1:0] bus_wstrb,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic             idx_load;
    logic             col_push;
    logic [CH_W-1:0]  top_byte;
    logic [IDX_W-1:0] cur_idx;
    phase_e           cur_phase;
    rgb_t             rd_rgb;
    logic             unused_low;

    assign top_byte   = bus_wdata[BUS_W-1 -: CH_W];
    assign unused_low = ^bus_wdata[BUS_W-CH_W-1:0];
    assign bus_rdata  = '0;
    assign pix_rgb    = rd_rgb;

    clut_decode u_decode (
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wstrb    (bus_wstrb),
        .idx_load (idx_load),
        .col_push (col_push)
    );

    clut_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .idx_load  (idx_load),
        .col_push  (col_push),
        .byte_in   (top_byte),
        .cur_idx   (cur_idx),
        .cur_phase (cur_phase)
    );

    clut_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (col_push),
        .w_idx   (cur_idx),
        .w_phase (cur_phase),
        .w_byte  (top_byte),
        .r_idx   (pix_idx),
        .r_rgb   (rd_rgb)
    );

    AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_wstrb != {STRB_W{1'b1}}) |=> $stable(cur_idx) && $stable(cur_phase)); // R5
    AST_STRAY_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr != OFF_INDEX && bus_addr != OFF_COLOR) |=> $stable(cur_idx) && $stable(cur_phase)); // R6
endmodule

// File: tb/tb_clut_port.sv
module tb_clut_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {index, red, green, blue}
    localparam logic [31:0] VEC [6] = '{
        32'h05_11_22_33, 32'h06_A0_B0_C0, 32'h80_FF_00_7F,
        32'h3C_01_02_04, 32'hFE_DE_AD_BE, 32'h07_5A_A5_C3
    };

    clut_port dut (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] b, input logic [3:0] s = 4'hF);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = {b, 24'hC3_5A_E1}; bus_wstrb = s;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wstrb = '0;
    endtask

    task automatic push_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        bus_wr(4'h4, r); bus_wr(4'h4, g); bus_wr(4'h4, b);
    endtask

    task automatic look(input logic [7:0] idx, output logic [23:0] rgb);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        rgb = pix_rgb;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] got;
        repeat (3) @(negedge clk);
        chk("R7 lookup output in reset", {8'h0, pix_rgb}, 32'h0);
        rst = 1'b0;

        look(8'd0, got);   chk("R7 entry 0 black", {8'h0, got}, 32'h0);
        look(8'd128, got); chk("R7 entry 128 black", {8'h0, got}, 32'h0);
        look(8'd255, got); chk("R7 entry 255 white", {8'h0, got}, 32'h00FF_FFFF);

        // reset index 0 and red phase: data without index load lands in entry 0
        push_rgb(8'h12, 8'h34, 8'h56);
        look(8'd0, got); chk("R7 default index/phase", {8'h0, got}, 32'h0012_3456);
        // auto-increment to entry 1
        push_rgb(8'h9A, 8'hBC, 8'hDE);
        look(8'd1, got); chk("R3 increment to entry 1", {8'h0, got}, 32'h009A_BCDE);

        for (int i = 0; i < 6; i++) begin
            bus_wr(4'h0, VEC[i][31:24]);
            push_rgb(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            look(VEC[i][31:24], got);
            chk("R2 table load", {8'h0, got}, {8'h0, VEC[i][23:0]});
        end

        // R1: reload partway through a colour
        bus_wr(4'h0, 8'd30);
        bus_wr(4'h4, 8'h71); bus_wr(4'h4, 8'h72);
        bus_wr(4'h0, 8'd31);
        push_rgb(8'h81, 8'h82, 8'h83);
        look(8'd30, got); chk("R1 abandoned entry", {8'h0, got}, 32'h0071_7200);
        look(8'd31, got); chk("R1 reload restarts red", {8'h0, got}, 32'h0081_8283);

        // R3: wrap from 255 to 0
        bus_wr(4'h0, 8'd255);
        push_rgb(8'h0A, 8'h0B, 8'h0C);
        push_rgb(8'h1A, 8'h1B, 8'h1C);
        look(8'd255, got); chk("R3 entry 255", {8'h0, got}, 32'h000A_0B0C);
        look(8'd0, got);   chk("R3 wrap to entry 0", {8'h0, got}, 32'h001A_1B1C);

        // R5: partial strobes dropped
        bus_wr(4'h0, 8'd10);
        bus_wr(4'h4, 8'hEE, 4'b0111);
        bus_wr(4'h0, 8'd99, 4'b1110);
        push_rgb(8'h21, 8'h22, 8'h23);
        look(8'd10, got); chk("R5 partial strobe dropped", {8'h0, got}, 32'h0021_2223);
        look(8'd99, got); chk("R5 partial index write dropped", {8'h0, got}, 32'h0);

        // R6: stray offsets ignored
        bus_wr(4'h0, 8'd20);
        bus_wr(4'h8, 8'h55); bus_wr(4'hC, 8'h66); bus_wr(4'h2, 8'h77); bus_wr(4'h6, 8'h44);
        push_rgb(8'h31, 8'h32, 8'h33);
        look(8'd20, got); chk("R6 stray offsets ignored", {8'h0, got}, 32'h0031_3233);

        // R8: write and lookup of same entry in one edge returns old value
        bus_wr(4'h0, 8'd40);
        bus_wr(4'h4, 8'h41); bus_wr(4'h4, 8'h42);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h4300_0000; bus_wstrb = 4'hF;
        pix_idx = 8'd40;
        chk("R4 rdata during write", bus_rdata, 32'h0);
        @(negedge clk);
        bus_wr_en = 1'b0;
        chk("R8 same-edge read old", {8'h0, pix_rgb}, 32'h0041_4200);
        @(negedge clk);
        chk("R8 next read new", {8'h0, pix_rgb}, 32'h0041_4243);

        chk("R4 rdata idle", bus_rdata, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule